// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

The block turns a decimal digit, presented one bit per clock on a single wire, into its Excess-3 form on a second wire. The digit arrives in 8421 weighting, least significant bit first. Each result bit is produced in the same cycle as the input bit it belongs to. A small Mealy state machine adds the constant three bit-serially. Its state holds the bit position inside the digit and the running carry. The output bit is a combinational function of that state and the present input bit.

Digits are framed only by counting. After reset the machine expects bit 0 of a digit. After every fourth bit it returns to its start state with the carry cleared, so the next digit can begin on the very next cycle. There are no framing, load or valid signals. The digit width and the added constant are parameters, and the defaults give the 4-bit, add-three code. State codes that can never be reached lead back to the start state on the next clock.

Top module: `bcd_xs3_serial`

## Requirements
- R1: While rst_ni is low and right after it rises, the machine is in its start state: the next input bit is taken as bit 0 of a new digit, with no carry pending.
- R2: Input bits are taken least significant bit first. Over four consecutive cycles, bit p of the output word, sampled in cycle p, equals bit p of (digit + 3) for every digit from 0 to 9.
- R3: The output is of Mealy type. In the start state bit_o equals the inverse of bit_i, and it follows a change of bit_i within the same cycle without waiting for a clock edge.
- R4: After the fourth bit of a digit the machine is back in its start state with the carry cleared, so digits may follow one another with no idle cycle.
- R5: The code is self-complementing: the output word for digit 9-d is the bitwise inverse, over 4 bits, of the output word for digit d.
- R6: Pulling rst_ni low in the middle of a digit puts the machine in its start state at once, without a clock edge. Conversion restarts cleanly once rst_ni is released.
- R7: Digit values 10 to 15 are converted by the same rule modulo 16, and the carry out of bit 3 is dropped. A following digit is converted correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial BCD input, least significant bit first |
| bit_o | output | 1 | Serial Excess-3 output, valid in the cycle of the matching input bit |

## Verification
The hardest case to reach from the ports is reset arriving inside a digit. Then the carry and position held in the state are partly built, and they must be discarded without a clock edge. The stimulus sends two bits of a digit whose low bits produce a carry. It then pulls reset low in the middle of a clock phase and checks the combinational output straight away against the start-state rule. It holds reset across an edge, releases it away from the edge, and converts a full digit sequence. The carry dropped out of bit 3 is reached by feeding the non-decimal values 13 and 15, each followed by an ordinary digit.

// File: rtl/xs3_pkg.sv
package xs3_pkg;

  // bit p of a non-negative constant
  function automatic logic const_bit(input int unsigned k, input int unsigned p);
    return ((k >> p) & 32'd1) != 32'd0;
  endfunction

  function automatic int unsigned pos_width(input int unsigned digit_w);
    return (digit_w > 1) ? $clog2(digit_w) : 1;
  endfunction

endpackage

// File: rtl/xs3_state_reg.sv
module xs3_state_reg #(
  parameter int unsigned ST_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] state_d_i,
  output logic [ST_W-1:0] state_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q_o <= '0;
    else         state_q_o <= state_d_i;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_start: assert (state_q_o == '0)
      else $error("state not at start during reset");
  end

endmodule

// File: rtl/xs3_step.sv
module xs3_step
  import xs3_pkg::*;
#(
  parameter int unsigned DIGIT_W = 4,
  parameter int unsigned OFFSET  = 3,
  parameter int unsigned POS_W   = 2
) (
  input  logic             bit_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             carry_i,
  output logic             bit_o,
  output logic [POS_W-1:0] pos_o,
  output logic             carry_o
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(DIGIT_W - 1);
  localparam logic             K0       = const_bit(OFFSET, 0);

  logic       legal;
  logic       k_bit;
  logic [1:0] sum;

  // a carry at position 0 is never reachable; out-of-range positions only exist
  // when DIGIT_W is not a power of two
  generate
    if ((2 ** POS_W) > DIGIT_W) begin : g_range_chk
      assign legal = (pos_i <= LAST_POS) && !((pos_i == '0) && carry_i);
    end else begin : g_full_range
      assign legal = !((pos_i == '0) && carry_i);
    end
  endgenerate

  assign k_bit = const_bit(OFFSET, 32'(pos_i));
  assign sum   = {1'b0, bit_i} + {1'b0, k_bit} + {1'b0, carry_i};

  always_comb begin
    if (!legal) begin
      bit_o   = bit_i ^ K0;
      pos_o   = '0;
      carry_o = 1'b0;
    end else if (pos_i == LAST_POS) begin
      bit_o   = sum[0];
      pos_o   = '0;
      carry_o = 1'b0;               // carry out of the top bit is dropped
    end else begin
      bit_o   = sum[0];
      pos_o   = pos_i + 1'b1;
      carry_o = sum[1];
    end
  end

endmodule

// File: rtl/bcd_xs3_serial.sv
module bcd_xs3_serial
  import xs3_pkg::*;
#(
  parameter int unsigned DIGIT_W = 4,
  parameter int unsigned OFFSET  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic bit_o
);

  localparam int unsigned      POS_W    = pos_width(DIGIT_W);
  localparam int unsigned      ST_W     = POS_W + 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(DIGIT_W - 1);

  logic [ST_W-1:0]  state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             carry_q, carry_d;

  assign pos_q   = state_q[POS_W-1:0];
  assign carry_q = state_q[POS_W];
  assign state_d = {carry_d, pos_d};

  xs3_state_reg #(.ST_W(ST_W)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_d_i(state_d),
    .state_q_o(state_q)
  );

  xs3_step #(.DIGIT_W(DIGIT_W), .OFFSET(OFFSET), .POS_W(POS_W)) u_step (
    .bit_i  (bit_i),
    .pos_i  (pos_q),
    .carry_i(carry_q),
    .bit_o  (bit_o),
    .pos_o  (pos_d),
    .carry_o(carry_d)
  );

  a_r4_wrap_to_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == LAST_POS) |=> (pos_q == '0 && !carry_q))
    else $error("no return to start after last bit");

  a_r2_pos_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q != LAST_POS) |=> (pos_q == POS_W'($past(pos_q) + 1'b1)))
    else $error("bit position did not advance");

  a_r1_start_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == '0) |-> !carry_q)
    else $error("carry pending at digit start");

  a_r3_start_inverts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == '0) |-> (bit_o == !bit_i))
    else $error("start-state output is not the inverse of the input");

endmodule

// File: tb/tb_bcd_xs3_serial.sv
module tb_bcd_xs3_serial;

  logic clk_i  = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_i  = 1'b0;
  logic bit_o;

  int n_cmp = 0;
  int n_bad = 0;
  int words [10];

  bcd_xs3_serial dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_i (bit_i),
    .bit_o (bit_o)
  );

  always #10 clk_i = ~clk_i;  // 20 ns period, 50 MHz

  task automatic chk(input int act, input int exp, input string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives one digit LSB first; the model is (d + 3) mod 16
  task automatic send_digit(input int d, input string req, output int word);
    int exp_word;
    exp_word = (d + 3) % 16;
    word = 0;
    for (int p = 0; p < 4; p++) begin
      @(negedge clk_i);
      bit_i = ((d >> p) & 1) != 0;
      #2;
      chk(int'(bit_o), (exp_word >> p) & 1, req);
      word = word | (int'(bit_o) << p);
    end
    chk(word, exp_word, req);
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w;
    // R1 / R3: start state during reset, combinational follow of bit_i
    #3;
    bit_i = 1'b0; #1;
    chk(int'(bit_o), 1, "R1 R3 reset in=0");
    bit_i = 1'b1; #1;
    chk(int'(bit_o), 0, "R3 same-cycle in=1");
    bit_i = 1'b0; #1;
    chk(int'(bit_o), 1, "R3 same-cycle in=0");
    @(posedge clk_i); @(posedge clk_i);
    #3 rst_ni = 1'b1;

    // R1: first digit after release
    send_digit(5, "R1", w);

    // R2 R4: all decimal digits back to back
    for (int d = 0; d < 10; d++) begin
      send_digit(d, "R2 R4", w);
      words[d] = w;
    end

    // R5: self-complementing
    for (int d = 0; d < 10; d++)
      chk(words[9 - d], (~words[d]) & 15, "R5");

    // R4: descending order, no gaps
    for (int d = 9; d >= 0; d--) send_digit(d, "R4", w);

    // R7: non-decimal values, carry dropped
    send_digit(13, "R7", w);
    send_digit(4, "R7 next", w);
    send_digit(15, "R7", w);
    send_digit(0, "R7 next", w);

    // R6: reset inside a digit with a carry pending (digit 1: bit0=1 -> carry)
    @(negedge clk_i); bit_i = 1'b1;
    @(negedge clk_i); bit_i = 1'b0;
    @(negedge clk_i); bit_i = 1'b1;
    #3 rst_ni = 1'b0;
    #1 chk(int'(bit_o), 0, "R6 async start");
    bit_i = 1'b0;
    #1 chk(int'(bit_o), 1, "R6 async start");
    @(posedge clk_i);
    #3 rst_ni = 1'b1;
    send_digit(6, "R6", w);
    send_digit(9, "R6", w);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule